// File: doc/BRIEF.md
# Single-Port Synchronous RAM with Selectable Write Behaviour

This block is a clocked single-port memory. Each rising edge of `clk` samples an address, a data word and three controls: `en`, `we` and `srst`. An enabled cycle either reads the addressed word into a registered output or writes the input word into the array. When `en` is low, the edge does nothing. A compile-time parameter decides what the output register shows during a write. It can show the word being written (write-first), the word the location held before (read-first), or keep its previous value (no-change).

The synchronous output reset acts only while the block is enabled. It loads a parameter value into the output register and never changes the array. A write requested in the same cycle as the reset is still stored. A second parameter gives the output register its power-up value, and every array word starts at zero.

Each cycle is decoded into one of four operations: IDLE (`en` low), RESET (`en` and `srst` high), WRITE (`en` and `we` high, `srst` low) and READ (`en` high, `we` and `srst` low). The output register moves to its next value in a single `unique case` on that operation. IDLE keeps the value. READ loads the stored word. WRITE loads the value the write mode selects. RESET loads the reset value. The array commits a write whenever `en` and `we` are both high, whatever the decoded operation.

Top module: `spram_wm`

## Requirements
- R1: With `en` low, an edge changes neither the array nor `dout`, whatever the values of `we`, `srst`, `addr` and `din`.
- R2: With `en` high and `we` and `srst` low, `dout` after the edge equals the word stored at the sampled `addr`, and the array is unchanged.
- R3: With `en` and `we` high, the edge stores `din` at the sampled `addr`, and a later read of that address returns it.
- R4: With `WR_MODE` = write-first (encoding 0), a write with `srst` low sets `dout` to `din` after the same edge.
- R5: With `WR_MODE` = read-first (encoding 1), a write with `srst` low sets `dout` to the word the address held before that edge.
- R6: With `WR_MODE` = no-change (encoding 2), a write with `srst` low leaves `dout` at its previous value.
- R7: With `en` and `srst` high, `dout` after the edge equals `RST_VAL` (default 16'h0101), and the array keeps its contents.
- R8: A write requested in the same cycle as an enabled `srst` is still stored, while `dout` shows `RST_VAL`.
- R9: Before the first enabled edge, `dout` equals `INIT_VAL`, and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every action happens on its rising edge |
| en | input | 1 | Enable; when low, the edge is ignored |
| we | input | 1 | Write enable, used only while `en` is high |
| srst | input | 1 | Synchronous output reset, used only while `en` is high |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data |

## Verification
The output reset and a write can fall in the same cycle. In that case the reset decides `dout` while the write must still reach the array. The bench provokes this by raising `srst` together with `we` at a fresh address, with new data. It judges the result twice: `dout` must show `RST_VAL` after that edge, and a plain read of the same address on the next cycle must return the data written under reset. The same stimulus is applied at once to three instances, one per write mode, so that one cycle also confirms that the reset overrides every write view.

// File: rtl/spram_pkg.sv
package spram_pkg;

    // Output-register behaviour while a write is in progress.
    typedef enum logic [1:0] {
        WM_WRITE_FIRST = 2'd0,
        WM_READ_FIRST  = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

    // Per-cycle operation seen by the output register.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RESET = 2'd3
    } op_e;

endpackage

// File: rtl/spram_decode.sv
module spram_decode
    import spram_pkg::*;
(
    input  logic en,
    input  logic we,
    input  logic srst,
    output op_e  op,
    output logic wr_commit
);

    // The array write does not depend on srst; the output operation does.
    always_comb begin
        wr_commit = en && we;
        if (!en)
            op = OP_IDLE;
        else if (srst)
            op = OP_RESET;
        else if (we)
            op = OP_WRITE;
        else
            op = OP_READ;
    end

endmodule

// File: rtl/spram_array.sv
module spram_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] old_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH] = '{default: '0};

    // Contents before this edge's write; the output stage registers it.
    assign old_word = cells[addr];

    always_ff @(posedge clk) begin
        if (wr)
            cells[addr] <= wdata;
    end

endmodule

// File: rtl/spram_outreg.sv
module spram_outreg
    import spram_pkg::*;
#(
    parameter int              DATA_W   = 16,
    parameter wmode_e          WR_MODE  = WM_WRITE_FIRST,
    parameter logic [DATA_W-1:0] RST_VAL  = 16'h0101,
    parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
    input  logic              clk,
    input  op_e               op,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] old_word,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] q = INIT_VAL;
    logic [DATA_W-1:0] q_nx;
    logic [DATA_W-1:0] wr_view;

    // The write mode picks which value the register takes during a write.
    generate
        if (WR_MODE == WM_WRITE_FIRST) begin : g_wf
            assign wr_view = wdata;
        end else if (WR_MODE == WM_READ_FIRST) begin : g_rf
            assign wr_view = old_word;
        end else begin : g_nc
            assign wr_view = q;
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_IDLE:  q_nx = q;
            OP_READ:  q_nx = old_word;
            OP_WRITE: q_nx = wr_view;
            OP_RESET: q_nx = RST_VAL;
            default:  q_nx = q;
        endcase
    end

    always_ff @(posedge clk) begin
        q <= q_nx;
    end

    assign dout = q;

endmodule

// File: rtl/spram_wm.sv
module spram_wm
    import spram_pkg::*;
#(
    parameter int                ADDR_W   = 10,
    parameter int                DATA_W   = 16,
    parameter wmode_e            WR_MODE  = WM_WRITE_FIRST,
    parameter logic [DATA_W-1:0] RST_VAL  = 16'h0101,
    parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic              srst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    op_e               op;
    logic              wr_commit;
    logic [DATA_W-1:0] old_word;

    spram_decode u_dec (
        .en        (en),
        .we        (we),
        .srst      (srst),
        .op        (op),
        .wr_commit (wr_commit)
    );

    spram_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_arr (
        .clk      (clk),
        .wr       (wr_commit),
        .addr     (addr),
        .wdata    (din),
        .old_word (old_word)
    );

    spram_outreg #(
        .DATA_W   (DATA_W),
        .WR_MODE  (WR_MODE),
        .RST_VAL  (RST_VAL),
        .INIT_VAL (INIT_VAL)
    ) u_out (
        .clk      (clk),
        .op       (op),
        .wdata    (din),
        .old_word (old_word),
        .dout     (dout)
    );

endmodule

// File: rtl/spram_wm_chk.sv
module spram_wm_chk
    import spram_pkg::*;
#(
    parameter int                ADDR_W  = 10,
    parameter int                DATA_W  = 16,
    parameter wmode_e            WR_MODE = WM_WRITE_FIRST,
    parameter logic [DATA_W-1:0] RST_VAL = 16'h0101
) (
    input logic              clk,
    input logic              en,
    input logic              we,
    input logic              srst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout
);

    // Enables the properties only once enough history exists for $past.
    logic [1:0] arm_q = 2'd0;
    always_ff @(posedge clk) begin
        if (arm_q != 2'd3)
            arm_q <= arm_q + 2'd1;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (arm_q != 2'd3)
        !en |=> $stable(dout)); // R1

    AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (arm_q != 2'd3)
        (en && !we && !srst && $past(en) && $past(we) && addr == $past(addr))
        |=> dout == $past(din, 2)); // R3

    AST_SRST_LOAD: assert property (@(posedge clk) disable iff (arm_q != 2'd3)
        (en && srst) |=> dout == RST_VAL); // R7

    generate
        if (WR_MODE == WM_WRITE_FIRST) begin : g_wf
            AST_WF_ECHO: assert property (@(posedge clk) disable iff (arm_q != 2'd3)
                (en && we && !srst) |=> dout == $past(din)); // R4
        end else if (WR_MODE == WM_NO_CHANGE) begin : g_nc
            AST_NC_HOLD: assert property (@(posedge clk) disable iff (arm_q != 2'd3)
                (en && we && !srst) |=> $stable(dout)); // R6
        end else begin : g_rf
            AST_RF_PRIOR: assert property (@(posedge clk) disable iff (arm_q != 2'd3)
                (en && we && !srst && $past(en) && $past(we) && addr == $past(addr))
                |=> dout == $past(din, 2)); // R5
        end
    endgenerate

endmodule

bind spram_wm spram_wm_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .WR_MODE (WR_MODE),
    .RST_VAL (RST_VAL)
) u_chk (
    .clk  (clk),
    .en   (en),
    .we   (we),
    .srst (srst),
    .addr (addr),
    .din  (din),
    .dout (dout)
);

// File: tb/sim_spram_wm.sv
`timescale 1ns/1ps
module sim_spram_wm;
    import spram_pkg::*;

    localparam int AW = 10;
    localparam int DW = 16;
    localparam logic [DW-1:0] RSTV = 16'h0101;
    localparam logic [DW-1:0] INITV = 16'h3C5A;

    typedef struct {
        logic [DW-1:0] exp [3];
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          en = 1'b0, we = 1'b0, srst = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout_wf, dout_rf, dout_nc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] ref_mem [1 << AW];
    logic [DW-1:0] ref_out [3];
    item_t         sb [$];

    always #5 clk = ~clk;

    spram_wm #(.ADDR_W(AW), .DATA_W(DW), .WR_MODE(WM_WRITE_FIRST),
               .RST_VAL(RSTV), .INIT_VAL(INITV)) u0 (
        .clk(clk), .en(en), .we(we), .srst(srst), .addr(addr), .din(din), .dout(dout_wf));
    spram_wm #(.ADDR_W(AW), .DATA_W(DW), .WR_MODE(WM_READ_FIRST),
               .RST_VAL(RSTV), .INIT_VAL(INITV)) u1 (
        .clk(clk), .en(en), .we(we), .srst(srst), .addr(addr), .din(din), .dout(dout_rf));
    spram_wm #(.ADDR_W(AW), .DATA_W(DW), .WR_MODE(WM_NO_CHANGE),
               .RST_VAL(RSTV), .INIT_VAL(INITV)) u2 (
        .clk(clk), .en(en), .we(we), .srst(srst), .addr(addr), .din(din), .dout(dout_nc));

    function automatic logic [DW-1:0] pick(int m);
        if (m == 0) return dout_wf;
        if (m == 1) return dout_rf;
        return dout_nc;
    endfunction

    task automatic check_all(string tag, logic [DW-1:0] e0, logic [DW-1:0] e1, logic [DW-1:0] e2);
        logic [DW-1:0] e [3];
        e[0] = e0; e[1] = e1; e[2] = e2;
        for (int m = 0; m < 3; m++) begin
            checks++;
            if (pick(m) !== e[m]) begin
                errors++;
                $display("FAIL %s mode%0d actual %h expected %h", tag, m, pick(m), e[m]);
            end
        end
    endtask

    // Driver: applies one cycle and pushes what each mode must show after the edge.
    task automatic cyc(bit e, bit w, bit r, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
        item_t it;
        @(negedge clk);
        en = e; we = w; srst = r; addr = a; din = d;
        for (int m = 0; m < 3; m++) begin
            if (!e)
                ref_out[m] = ref_out[m];
            else if (r)
                ref_out[m] = RSTV;
            else if (!w)
                ref_out[m] = ref_mem[a];
            else if (m == 0)
                ref_out[m] = d;
            else if (m == 1)
                ref_out[m] = ref_mem[a];
            it.exp[m] = ref_out[m];
        end
        for (int m = 0; m < 3; m++) it.exp[m] = ref_out[m];
        if (e && w) ref_mem[a] = d;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check_all(it.tag, it.exp[0], it.exp[1], it.exp[2]);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
        for (int m = 0; m < 3; m++) ref_out[m] = INITV;
        #1;
        check_all("R9 power-up output", INITV, INITV, INITV);

        cyc(0, 1, 1, 10'h00F, 16'h1234, "R1 disabled edge");
        cyc(1, 0, 0, 10'h000, 16'h0000, "R2 R9 read 00 zero");
        cyc(1, 1, 0, 10'h07E, 16'hBBBB, "R4 R5 R6 write 7E");
        cyc(1, 1, 0, 10'h00F, 16'hCCCC, "R4 R5 R6 write 0F");
        cyc(1, 0, 0, 10'h07E, 16'h0000, "R2 R3 read 7E");
        cyc(1, 1, 0, 10'h07E, 16'hAAAA, "R5 R6 overwrite 7E");
        cyc(1, 1, 0, 10'h00F, 16'hDDDD, "R4 R5 R6 overwrite 0F");
        cyc(1, 0, 1, 10'h020, 16'h0000, "R7 output reset");
        cyc(1, 0, 0, 10'h00F, 16'h0000, "R7 array kept after reset");
        cyc(1, 1, 1, 10'h020, 16'h5555, "R8 reset with write");
        cyc(1, 0, 0, 10'h020, 16'h0000, "R8 write under reset stored");
        cyc(0, 1, 0, 10'h020, 16'h9999, "R1 disabled write");
        cyc(1, 0, 0, 10'h020, 16'h0000, "R1 array unchanged");
        cyc(0, 0, 1, 10'h020, 16'h0000, "R1 reset ignored when disabled");
        cyc(1, 0, 0, 10'h07E, 16'h0000, "R3 read 7E after overwrite");

        lfsr = 16'hACE1;
        for (int k = 0; k < 60; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0] | lfsr[1], lfsr[2], lfsr[3] & lfsr[4], {7'd0, lfsr[7:5]}, lfsr ^ 16'h5A5A,
                "R2 R3 R4 R5 R6 mixed traffic");
        end

        @(negedge clk);
        en = 0;
        @(posedge clk);
        #3;
        finish_run();
    end

endmodule